// File: doc/BRIEF.md
# Oversampled Serial Byte Transmitter

This block turns bytes into asynchronous serial frames while running entirely on one fast system clock. The bit rate is set by a separate, slower baud clock whose phase has no fixed relation to the system clock. That baud clock is never used to clock a flip-flop. It passes through a chain of synchronizing registers, and each rising transition seen in the fast domain becomes a one-cycle shift enable.

A send strobe only needs to last a single fast-clock cycle, which can be far shorter than one baud period. The strobe is caught in a pending flag, and the frame is loaded on the next shift enable. Each frame is eleven bits long: a low start bit, the eight data bits with bit 0 first, and two high stop bits. A busy flag shows when a frame is in flight. A strobe that arrives during a frame is discarded.

Top module: `serial_byte_tx`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `line_o` is 1 and `busy_o` is 0. Reset also clears any pending request, so no frame follows the reset unless a new strobe arrives.
- R2: A frame occupies eleven consecutive baud periods. Measured at the middle of each period, the line shows 0 (start), then `data_i[0]` up to `data_i[7]`, then 1 and 1 (stop).
- R3: When no frame is being shifted, `line_o` is 1.
- R4: `busy_o` is 1 from the load of a frame through the first stop bit. It is 0 by the middle of the second stop bit.
- R5: A `send_i` pulse one fast-clock cycle wide is accepted. The start bit appears in the baud period that begins at the first baud rising edge after the pulse.
- R6: A `send_i` pulse that arrives while `busy_o` is 1 is dropped. It does not change the current frame and does not start another frame after it.
- R7: The line advances only after a rising edge of `baud_i`, sampled through two synchronizing registers. While `baud_i` is held constant, the line and the busy flag keep their values, and a pending request waits.
- R8: A strobe issued during the second stop bit starts a new frame whose start bit fills the very next baud period.
- R9: One accepted strobe produces exactly one frame. The pending flag clears when the frame loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_i | input | 1 | Synchronous reset, active high |
| baud_i | input | 1 | Raw baud clock, asynchronous to clk_i |
| data_i | input | DATA_W | Byte to send, captured when the frame loads |
| send_i | input | 1 | Send strobe, may be one clk_i cycle long |
| line_o | output | 1 | Serial output, high when idle |
| busy_o | output | 1 | High while a frame occupies the shift register |

## Verification
The byte patterns in the table (all zeros, all ones, alternating bits, and single bits at each end) are chosen to expose different faults. They separate a reversed bit order from a correct one. They reveal a data bit that is stuck or dropped, and they show a stop bit that has been confused with data. The table is sent back to back, so every frame after the first also checks that a strobe given in the second stop bit starts the next frame one period later. Directed cases then cover:
- a strobe issued mid-frame;
- a baud clock frozen before a frame and during one;
- a reset that lands mid-frame;
- a reset between a strobe and its load.

Each case shows whether requests are dropped, held or cleared as required.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

   // number of bits in one frame: start + data + stops
   function automatic int frame_len(input int data_w, input int stop_bits);
      return 1 + data_w + stop_bits;
   endfunction

   // minimum synchronizer depth accepted for the baud input
   localparam int MIN_SYNC = 2;

endpackage

// File: rtl/sbt_baud_sync.sv
module sbt_baud_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic baud_i,
   output logic tick_o
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              synced;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], baud_i};
         prev_q <= synced;
      end
   end

   assign synced = sync_q[STAGES-1];
   assign tick_o = synced & ~prev_q;

endmodule

// File: rtl/sbt_req_latch.sv
module sbt_req_latch (
   input  logic clk_i,
   input  logic rst_i,
   input  logic send_i,
   input  logic idle_i,
   input  logic tick_i,
   output logic load_o,
   output logic pending_o
);

   logic pend_q;

   assign load_o    = pend_q & tick_i & idle_i;
   assign pending_o = pend_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         pend_q <= 1'b0;
      else if (load_o)
         pend_q <= 1'b0;
      else if (send_i && idle_i)
         pend_q <= 1'b1;
   end

endmodule

// File: rtl/sbt_frame_shifter.sv
module sbt_frame_shifter #(
   parameter int DATA_W    = 8,
   parameter int STOP_BITS = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic              tick_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              line_o,
   output logic              idle_o
);

   localparam int FW = sbt_pkg::frame_len(DATA_W, STOP_BITS);
   localparam logic [FW-1:0] IDLE_PAT = FW'(1);

   logic [FW-1:0] frame_q;
   logic [FW-1:0] frame_init;

   assign frame_init = {{STOP_BITS{1'b1}}, data_i, 1'b0};
   assign idle_o     = (frame_q == IDLE_PAT);
   assign line_o     = frame_q[0];

   always_ff @(posedge clk_i) begin
      if (rst_i)
         frame_q <= IDLE_PAT;
      else if (load_i)
         frame_q <= frame_init;
      else if (tick_i && !idle_o)
         frame_q <= {1'b0, frame_q[FW-1:1]};
   end

endmodule

// File: rtl/serial_byte_tx.sv
module serial_byte_tx #(
   parameter int DATA_W      = 8,
   parameter int STOP_BITS   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              baud_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              send_i,
   output logic              line_o,
   output logic              busy_o
);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("serial_byte_tx: DATA_W must be at least 1");
      end
      if (STOP_BITS < 1) begin : g_bad_stop
         $error("serial_byte_tx: STOP_BITS must be at least 1");
      end
      if (SYNC_STAGES < sbt_pkg::MIN_SYNC) begin : g_bad_sync
         $error("serial_byte_tx: SYNC_STAGES below minimum");
      end
   endgenerate

   logic w_tick;
   logic w_load;
   logic w_idle;
   logic w_pending;

   sbt_baud_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .baud_i (baud_i),
      .tick_o (w_tick)
   );

   sbt_req_latch u_req (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .send_i    (send_i),
      .idle_i    (w_idle),
      .tick_i    (w_tick),
      .load_o    (w_load),
      .pending_o (w_pending)
   );

   sbt_frame_shifter #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_shift (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (w_load),
      .tick_i (w_tick),
      .data_i (data_i),
      .line_o (line_o),
      .idle_o (w_idle)
   );

   assign busy_o = ~w_idle;

endmodule

// File: rtl/sbt_chk.sv
module sbt_chk (
   input logic clk_i,
   input logic rst_i,
   input logic line_o,
   input logic busy_o,
   input logic tick,
   input logic load,
   input logic pending
);

   logic rst_d = 1'b0;

   always_ff @(posedge clk_i) begin
      rst_d <= rst_i;
      // R1
      if (rst_d) begin
         reset_idle_chk: assert (line_o && !busy_o);
      end
   end

   // R2
   start_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      load |=> (!line_o && busy_o));

   // R3
   idle_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !busy_o |-> line_o);

   // R6
   no_load_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      busy_o |-> !load);

   // R7
   hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !tick |=> ($stable(line_o) && $stable(busy_o)));

   // R7
   tick_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      tick |=> !tick);

   // R9
   pend_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      load |=> !pending);

endmodule

bind serial_byte_tx sbt_chk u_sbt_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .line_o  (line_o),
   .busy_o  (busy_o),
   .tick    (w_tick),
   .load    (w_load),
   .pending (w_pending)
);

// File: tb/test_serial_byte_tx.sv
`timescale 1ns/1ps
module test_serial_byte_tx;

   localparam int P    = 40;
   localparam int HALF = 20;
   localparam int NV   = 6;
   localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       send = 1'b0;
   logic [7:0] data = 8'h00;
   logic       line, busy, baud;
   int         cnt = 0;
   bit         baud_run = 1'b1;
   int         n_run = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   always @(negedge clk) if (baud_run) cnt <= (cnt == P-1) ? 0 : cnt + 1;
   assign baud = (cnt < HALF);

   serial_byte_tx i_serial_byte_tx (
      .clk_i(clk), .rst_i(rst), .baud_i(baud), .data_i(data),
      .send_i(send), .line_o(line), .busy_o(busy)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_mid();
      do begin @(negedge clk); #1; end while (cnt != HALF);
   endtask

   task automatic pulse_send(input logic [7:0] d);
      @(negedge clk); data = d; send = 1'b1;
      @(negedge clk); send = 1'b0;
   endtask

   // observe one frame already requested; optional mid-frame send and freeze
   task automatic watch_frame(input logic [7:0] d, input int inject_at, input int freeze_at);
      for (int b = 0; b < 11; b++) begin
         logic exp_bit;
         wait_mid();
         exp_bit = (b == 0) ? 1'b0 : (b <= 8) ? d[b-1] : 1'b1;
         chk("R2 frame bit", line, exp_bit);
         chk("R4 busy", busy, (b <= 9));
         if (b == inject_at) pulse_send(~d);
         if (b == freeze_at) begin
            baud_run = 1'b0;
            repeat (100) @(negedge clk);
            #1;
            chk("R7 frozen line", line, exp_bit);
            chk("R7 frozen busy", busy, 1'b1);
            baud_run = 1'b1;
         end
      end
   endtask

   task automatic expect_quiet(input string req, input int periods);
      for (int k = 0; k < periods; k++) begin
         wait_mid();
         chk(req, line, 1'b1);
         chk(req, busy, 1'b0);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      end
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      #1;
      chk("R1 reset line", line, 1'b1);
      chk("R1 reset busy", busy, 1'b0);
      rst = 1'b0;
      @(negedge clk); #1;
      chk("R1 after release line", line, 1'b1);
      chk("R1 after release busy", busy, 1'b0);

      // table walk: back-to-back frames (R5, R8)
      wait_mid();
      chk("R3 idle line", line, 1'b1);
      for (int v = 0; v < NV; v++) begin
         pulse_send(VEC[v]);   // R5 one-cycle strobe, R8 issued in second stop bit
         watch_frame(VEC[v], -1, -1);
      end
      expect_quiet("R9 single frame per strobe", 2);

      // R6: send during frame is dropped
      pulse_send(8'h96);
      watch_frame(8'h96, 3, -1);
      expect_quiet("R6 dropped request", 3);

      // R7: baud held before a frame; request waits
      baud_run = 1'b0;
      pulse_send(8'h3C);
      repeat (200) @(negedge clk);
      #1;
      chk("R7 held line", line, 1'b1);
      chk("R7 held busy", busy, 1'b0);
      baud_run = 1'b1;
      watch_frame(8'h3C, -1, 4);
      expect_quiet("R9 no repeat", 2);

      // R1: reset mid-frame
      pulse_send(8'h00);
      wait_mid();
      chk("R2 start before reset", line, 1'b0);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk); #1;
      chk("R1 mid-frame reset line", line, 1'b1);
      chk("R1 mid-frame reset busy", busy, 1'b0);
      expect_quiet("R1 no resume", 2);

      // R1: reset between strobe and load clears pending
      wait_mid();
      pulse_send(8'h00);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      expect_quiet("R1 pending cleared", 2);

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      end
      $finish;
   end

endmodule